// File: doc/BRIEF.md
# Character LCD Row Scan and Segment Transfer Generator

This block paces the multiplexed drive of a dot-matrix character panel that has 16 row (common) electrodes and 40 column (segment) electrodes. It advances one step on each cycle of an oscillator-rate clock enable. The line count and font height inputs select the duty, which is the number of commons scanned per frame. The duty also sets how many enabled cycles each common stays selected.

Within each row the block opens a 40-cycle window in which serial pattern bits are shifted into an internal 40-bit register. A separate one-cycle strobe at the end of the row copies that register into the parallel segment latch and moves the scan to the next common. A frame-rate polarity signal flips each time the scan wraps back to the first common. This polarity signal is what lets the panel drivers alternate the drive waveform so that the liquid crystal sees no DC component.

Top module: `lcd_scan_gen`

## Requirements
- R1: The number of commons scanned per frame is 16 when `twoLine`=1. It is 8 when `twoLine`=0 and `tallFont`=0, and 11 when `twoLine`=0 and `tallFont`=1. `comIdx` runs from 0 up to that count minus 1.
- R2: Each row lasts 200 enabled cycles at 16 commons and 400 enabled cycles otherwise. `latchStb` is high for exactly one enabled cycle per row, the last one.
- R3: Each `latchStb` cycle advances `comIdx` by one. From the last row of the frame it wraps to 0 instead.
- R4: `comSel` is one-hot at bit `comIdx` while `comIdx` is below the current common count, and all zero otherwise. A bit at or above the common count is never set.
- R5: `acFlip` toggles exactly once per frame, on the edge where `comIdx` wraps to 0.
- R6: `dataValid` is high during the first 40 cycles of each row (row cycle 0 to 39). `shiftClk` is high on enabled cycles inside that window. `serData` has no effect outside it.
- R7: On `latchStb`, `segLatch` loads the shift register. The first serial bit of the row lands in `segLatch[39]` and the 40th in `segLatch[0]`. `segLatch` holds its value at all other times.
- R8: While `oscEn`=0, no state changes and `shiftClk` and `latchStb` stay low.
- R9: A synchronous active-high `rst` returns `comIdx` to 0 and sets `acFlip` low. It also clears the row counter, the shift register and `segLatch`.
- R10: If the common count drops below `comIdx+1` in the middle of a frame, `comSel` goes all-zero at once. At the next row boundary `comIdx` wraps to 0 and `acFlip` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oscEn | input | 1 | Oscillator-rate clock enable |
| twoLine | input | 1 | 1 selects two-line mode (16 commons) |
| tallFont | input | 1 | 1 selects the tall font in one-line mode (11 commons) |
| serData | input | 1 | Serial segment pattern bit |
| comIdx | output | 4 | Index of the active common |
| comSel | output | 16 | One-hot selected common, zero for unused commons |
| shiftClk | output | 1 | Serial shift strobe |
| latchStb | output | 1 | Segment latch strobe at the end of a row |
| dataValid | output | 1 | Serial transfer window of the current row |
| acFlip | output | 1 | Frame polarity for the drive waveform |
| segLatch | output | 40 | Parallel segment pattern for the active row |

## Verification
`shiftClk`, `latchStb`, `dataValid` and `comSel` are combinational, so they reflect the inputs and row count of the current cycle. The bench reads them 1 ns after it drives inputs at the falling edge. `comIdx`, `acFlip` and `segLatch` change on the rising edge that consumes the strobe. A row therefore finishes `rowLen` edges after it starts, and a frame finishes `duty*rowLen` edges after reset. The bench counts falling edges from reset release and samples at exactly those counts. The last cycle before each boundary is also checked, to confirm that nothing has moved early.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic latch;
  } scanStb_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM    = 16,
  parameter int NUM_SEG    = 40,
  parameter int ROW_LONG   = 400,
  parameter int ROW_SHORT  = 200,
  parameter int DUTY_SHORT = 8,
  parameter int DUTY_TALL  = 11,
  localparam int COM_W = $clog2(NUM_COM),
  localparam int CNT_W = $clog2(ROW_LONG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oscEn,
  input  logic             twoLine,
  input  logic             tallFont,
  output scanStb_t         stb,
  output logic [COM_W-1:0] comIdx,
  output logic [COM_W:0]   dutyRows,
  output logic             dataValid,
  output logic             acFlip
);
  logic [CNT_W-1:0] rowCnt;
  logic [CNT_W-1:0] rowLast;
  logic             wrapNow;

  always_comb begin
    if (twoLine)       dutyRows = (COM_W+1)'(NUM_COM);
    else if (tallFont) dutyRows = (COM_W+1)'(DUTY_TALL);
    else               dutyRows = (COM_W+1)'(DUTY_SHORT);
    rowLast   = twoLine ? CNT_W'(ROW_SHORT - 1) : CNT_W'(ROW_LONG - 1);
    dataValid = (rowCnt < CNT_W'(NUM_SEG));
    stb.shift = oscEn & dataValid;
    // >= covers a switch to the short row while past its end
    stb.latch = oscEn & (rowCnt >= rowLast);
    wrapNow   = ({1'b0, comIdx} >= (dutyRows - (COM_W+1)'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowCnt <= '0;
      comIdx <= '0;
      acFlip <= 1'b0;
    end else if (stb.latch) begin
      rowCnt <= '0;
      if (wrapNow) begin
        comIdx <= '0;
        acFlip <= ~acFlip;
      end else begin
        comIdx <= comIdx + COM_W'(1);
      end
    end else if (oscEn) begin
      rowCnt <= rowCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 40,
  localparam int COM_W = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  scanStb_t           stb,
  input  logic               serData,
  input  logic [COM_W-1:0]   comIdx,
  input  logic [COM_W:0]     dutyRows,
  output logic [NUM_COM-1:0] comSel,
  output logic [NUM_SEG-1:0] segLatch
);
  logic [NUM_SEG-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      segLatch <= '0;
    end else begin
      if (stb.shift) shiftReg <= {shiftReg[NUM_SEG-2:0], serData};
      if (stb.latch) segLatch <= shiftReg;
    end
  end

  // common decode, masked to the active duty
  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign comSel[i] = (comIdx == COM_W'(i)) && ((COM_W+1)'(i) < dutyRows);
  end
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM    = 16,
  parameter int NUM_SEG    = 40,
  parameter int ROW_LONG   = 400,
  parameter int ROW_SHORT  = 200,
  parameter int DUTY_SHORT = 8,
  parameter int DUTY_TALL  = 11,
  localparam int COM_W = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oscEn,
  input  logic               twoLine,
  input  logic               tallFont,
  input  logic               serData,
  output logic [COM_W-1:0]   comIdx,
  output logic [NUM_COM-1:0] comSel,
  output logic               shiftClk,
  output logic               latchStb,
  output logic               dataValid,
  output logic               acFlip,
  output logic [NUM_SEG-1:0] segLatch
);
  scanStb_t         stb;
  logic [COM_W:0]   dutyRows;

  lcd_scan_ctrl #(
    .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .ROW_LONG(ROW_LONG),
    .ROW_SHORT(ROW_SHORT), .DUTY_SHORT(DUTY_SHORT), .DUTY_TALL(DUTY_TALL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .oscEn(oscEn), .twoLine(twoLine),
    .tallFont(tallFont), .stb(stb), .comIdx(comIdx),
    .dutyRows(dutyRows), .dataValid(dataValid), .acFlip(acFlip)
  );

  lcd_scan_dp #(
    .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .serData(serData),
    .comIdx(comIdx), .dutyRows(dutyRows), .comSel(comSel),
    .segLatch(segLatch)
  );

  assign shiftClk = stb.shift;
  assign latchStb = stb.latch;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 40,
  localparam int COM_W = $clog2(NUM_COM)
) (
  input logic               clk,
  input logic               rst,
  input logic               oscEn,
  input logic [COM_W-1:0]   comIdx,
  input logic [NUM_COM-1:0] comSel,
  input logic               shiftClk,
  input logic               latchStb,
  input logic               dataValid,
  input logic               acFlip,
  input logic [NUM_SEG-1:0] segLatch
);
  // R3: a row boundary steps the index by one or wraps it
  a_r3_com_step: assert property (@(posedge clk) disable iff (rst)
    latchStb |=> (comIdx == $past(comIdx) + COM_W'(1)) || (comIdx == '0));

  // R4: at most one common selected, and it matches the index
  a_r4_one_sel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(comSel));
  a_r4_sel_match: assert property (@(posedge clk) disable iff (rst)
    (comSel != '0) |-> comSel[comIdx]);

  // R5: polarity changes only at a frame wrap
  a_r5_ac_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(acFlip) |-> (comIdx == '0) && $past(latchStb));

  // R6: shifting only inside the transfer window
  a_r6_shift_window: assert property (@(posedge clk) disable iff (rst)
    shiftClk |-> dataValid);

  // R7: latch holds between strobes
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !latchStb |=> $stable(segLatch));

  // R8: no enable, no progress
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !oscEn |=> $stable(comIdx) && $stable(acFlip));
endmodule

bind lcd_scan_gen lcd_scan_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (.*);

// File: tb/tb_lcd_scan_gen.sv
module tb_lcd_scan_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oscEn = 1'b0;
  logic        twoLine = 1'b0;
  logic        tallFont = 1'b0;
  logic        serData = 1'b0;
  logic [3:0]  comIdx;
  logic [15:0] comSel;
  logic        shiftClk, latchStb, dataValid, acFlip;
  logic [39:0] segLatch;

  int checks = 0;
  int failures = 0;

  // {twoLine, tallFont, commons per frame, cycles per row}
  localparam int VEC [3][4] = '{
    '{1, 0, 16, 200},
    '{0, 0,  8, 400},
    '{0, 1, 11, 400}
  };
  localparam logic [39:0] PAT = 40'hA53C960F1E;

  lcd_scan_gen dut (
    .clk(clk), .rst(rst), .oscEn(oscEn), .twoLine(twoLine),
    .tallFont(tallFont), .serData(serData), .comIdx(comIdx),
    .comSel(comSel), .shiftClk(shiftClk), .latchStb(latchStb),
    .dataValid(dataValid), .acFlip(acFlip), .segLatch(segLatch)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    oscEn = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state, R9
    twoLine = 1'b1;
    doReset();
    #1;
    check(comIdx == 0 && acFlip == 0 && segLatch == 0, "R9 reset state",
          {comIdx, acFlip, segLatch}, 0);
    check(comSel == 16'h0001, "R4 reset select", comSel, 1);

    // table-driven frame walks: R1 R2 R3 R4 R5
    for (int v = 0; v < 3; v++) begin
      int cnt, lat, l1, l2, maxIdx, badSel;
      bit done;
      twoLine  = VEC[v][0][0];
      tallFont = VEC[v][1][0];
      doReset();
      cnt = 0; lat = 0; l1 = 0; l2 = 0; maxIdx = 0; badSel = 0; done = 0;
      #1;
      while (!done && cnt < 20000) begin
        if (latchStb) begin
          lat++;
          if (lat == 1) l1 = cnt;
          if (lat == 2) l2 = cnt;
        end
        if (int'(comIdx) > maxIdx) maxIdx = int'(comIdx);
        if (comSel != (16'h1 << comIdx)) badSel++;
        if (int'(comIdx) >= VEC[v][2] && comSel != 0) badSel++;
        @(negedge clk);
        #1;
        cnt++;
        if (acFlip) done = 1;
      end
      check(cnt == VEC[v][2] * VEC[v][3], "R5 R1 frame length", cnt, VEC[v][2] * VEC[v][3]);
      check(lat == VEC[v][2], "R2 strobes per frame", lat, VEC[v][2]);
      check(l2 - l1 == VEC[v][3], "R2 row length", l2 - l1, VEC[v][3]);
      check(maxIdx == VEC[v][2] - 1, "R3 highest index", maxIdx, VEC[v][2] - 1);
      check(badSel == 0, "R4 select decode", badSel, 0);
      check(comIdx == 0, "R3 wrap to zero", comIdx, 0);
    end

    // clock enable low, R8
    begin
      logic [3:0] idx0;
      logic       ac0;
      int         strobes;
      @(negedge clk);
      oscEn = 1'b0;
      #1;
      idx0 = comIdx; ac0 = acFlip; strobes = 0;
      repeat (50) begin
        @(negedge clk);
        #1;
        if (shiftClk || latchStb) strobes++;
      end
      check(strobes == 0, "R8 no strobes while idle", strobes, 0);
      check(comIdx == idx0 && acFlip == ac0, "R8 state frozen", {comIdx, acFlip}, {idx0, ac0});
    end

    // reset mid-run after a frame, R9
    doReset();
    #1;
    check(comIdx == 0 && acFlip == 0, "R9 reset after frame", {comIdx, acFlip}, 0);

    // serial transfer in 16-common mode, R6 R7
    twoLine = 1'b1; tallFont = 1'b0;
    doReset();
    for (int k = 0; k < 200; k++) begin
      serData = (k < 40) ? PAT[39 - k] : ((k % 3) == 0);
      if (k == 39) begin
        #1;
        check(dataValid && shiftClk, "R6 last window cycle open", {dataValid, shiftClk}, 3);
      end
      if (k == 40) begin
        #1;
        check(!dataValid && !shiftClk, "R6 window closed", {dataValid, shiftClk}, 0);
      end
      if (k == 199) begin
        #1;
        check(segLatch == 0 && latchStb, "R7 latch before boundary", segLatch, 0);
      end
      @(negedge clk);
    end
    #1;
    check(segLatch == PAT, "R7 R6 pattern latched", segLatch, PAT);
    check(comIdx == 1, "R3 next row", comIdx, 1);

    // mode change past active duty, R10
    repeat (11 * 200) @(negedge clk);
    #1;
    check(comIdx == 12, "R3 reached row 12", comIdx, 12);
    @(negedge clk);
    twoLine = 1'b0;
    #1;
    check(comSel == 0, "R10 R4 beyond duty deselected", comSel, 0);
    repeat (398) @(negedge clk);
    #1;
    check(comIdx == 12 && !acFlip, "R10 still waiting", {comIdx, acFlip}, 12 << 1);
    @(negedge clk);
    #1;
    check(comIdx == 0 && acFlip, "R10 R5 wrap at boundary", {comIdx, acFlip}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule